// File: doc/BRIEF.md
# Mode-Banked Processor Register File

This block holds the sixteen 32-bit general registers of a small processor that runs in several privilege modes, together with its status word and a per-mode saved-status word. A 5-bit mode field sits in the low bits of the status word. Some registers have a separate physical copy for each mode, and the active mode selects which copy the ports see. When a status write moves the processor into a different mode, the stack pointer (R13), the link register (R14) and the saved-status word shown at the ports switch to the incoming mode's copies. The fast-interrupt mode also owns a private set of R8 to R12.

The block has two combinational read ports, one general write port, a saved-status write port and a status write port. It shows the status word and the current mode field as plain outputs. While reset is held, the block samples a boot status value. It keeps that value only if the value's mode field is legal.

Each mode copy is stored in place and picked by the decoded mode. Nothing is copied when the mode changes, but the ports behave exactly as if the outgoing mode's values had been saved and the incoming mode's values restored.

Top module: `bankreg_file`

## Requirements
- R1: The mode field is status bits [4:0]. The legal codes are 0x10 user, 0x11 fast interrupt, 0x12 interrupt, 0x13 supervisor, 0x17 abort, 0x1B undefined and 0x1F system. `cur_mode` always equals status bits [4:0], and it always holds one of these legal codes.
- R2: Reset is synchronous and active low. During reset, every general register and every saved-status copy clears to zero. The status word loads `boot_sts` if its mode field is legal, and 0x0000_00D3 otherwise (supervisor mode with bits 7 and 6, the two interrupt-disable bits, set).
- R3: A status write whose new mode field is legal replaces the whole status word at the clock edge. If the new mode equals the current mode, the banked values seen at the ports do not change.
- R4: A status write whose new mode field is illegal updates status bits [31:5] and leaves the mode field unchanged, so no bank changes.
- R5: R13 and R14 each have six copies: user/system (shared), fast interrupt, interrupt, supervisor, abort and undefined. A read returns the current mode's copy. A value written in one mode reappears when that mode is entered again.
- R6: R8 to R12 have two copies: one for fast-interrupt mode and one shared by every other mode.
- R7: The saved-status word has one copy per bank, arranged like R13 and R14. `ssr_q` shows the current mode's copy, and `ssr_wr_en` writes that copy.
- R8: R0 to R7 and R15 have a single copy that every mode sees.
- R9: Writes take effect at the clock edge, and reads do not bypass a write made in the same cycle. A general or saved-status write made in the same cycle as a mode-changing status write lands in the outgoing mode's copy. From the next cycle, reads show the incoming mode's copies.
- R10: The two read ports are independent. Both may read any index, including the same one, in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| boot_sts | input | 32 | Status value loaded during reset if its mode is legal |
| rd_a_idx | input | 4 | Read port A register index |
| rd_a_data | output | 32 | Read port A data (current mode's copy) |
| rd_b_idx | input | 4 | Read port B register index |
| rd_b_data | output | 32 | Read port B data (current mode's copy) |
| wr_en | input | 1 | General register write enable |
| wr_idx | input | 4 | General register write index |
| wr_data | input | 32 | General register write data |
| ssr_wr_en | input | 1 | Saved-status write enable for the current mode |
| ssr_wr_data | input | 32 | Saved-status write data |
| ssr_q | output | 32 | Current mode's saved-status word |
| sts_wr_en | input | 1 | Status word write enable |
| sts_wr_data | input | 32 | Status word write data |
| sts_q | output | 32 | Status word |
| cur_mode | output | 5 | Current mode field |

## Verification
The hardest case to reach is a register or saved-status write made in the same cycle as a mode-changing status write. The data must land in the outgoing bank and then stay hidden until that mode is entered again. A mistake here shows up only several switches later, and only if the intermediate modes never overwrite that copy. A directed sequence sets up this collision and returns to the mode to confirm the value. A long random run then mixes legal and illegal mode codes with writes to every index, and a swap-based reference model is compared against every output on every cycle.

// File: rtl/brf_pkg.sv
package brf_pkg;
  localparam int NBANK = 6;

  typedef enum logic [2:0] {
    BK_USR = 3'd0,
    BK_FIQ = 3'd1,
    BK_IRQ = 3'd2,
    BK_SVC = 3'd3,
    BK_ABT = 3'd4,
    BK_UND = 3'd5
  } bank_e;

  localparam logic [4:0] MF_USR = 5'h10;
  localparam logic [4:0] MF_FIQ = 5'h11;
  localparam logic [4:0] MF_IRQ = 5'h12;
  localparam logic [4:0] MF_SVC = 5'h13;
  localparam logic [4:0] MF_ABT = 5'h17;
  localparam logic [4:0] MF_UND = 5'h1B;
  localparam logic [4:0] MF_SYS = 5'h1F;

  localparam logic [31:0] SAFE_STS = 32'h0000_00D3;
endpackage

// File: rtl/brf_mode_decode.sv
module brf_mode_decode
  import brf_pkg::*;
(
  input  logic [4:0] mf,
  output logic       legal,
  output bank_e      bank
);
  always_comb begin
    legal = 1'b1;
    bank  = BK_SVC;
    unique case (mf)
      MF_USR:  bank = BK_USR;
      MF_SYS:  bank = BK_USR;
      MF_FIQ:  bank = BK_FIQ;
      MF_IRQ:  bank = BK_IRQ;
      MF_SVC:  bank = BK_SVC;
      MF_ABT:  bank = BK_ABT;
      MF_UND:  bank = BK_UND;
      default: legal = 1'b0;
    endcase
  end
endmodule

// File: rtl/brf_status_ctl.sv
module brf_status_ctl
  import brf_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] boot_sts,
  input  logic          we,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] sts_q,
  output bank_e         bank
);
  logic  boot_ok, new_ok, cur_ok;
  bank_e boot_bk, new_bk;

  brf_mode_decode u_dec_boot (.mf(boot_sts[4:0]), .legal(boot_ok), .bank(boot_bk));
  brf_mode_decode u_dec_new  (.mf(wdata[4:0]),    .legal(new_ok),  .bank(new_bk));
  brf_mode_decode u_dec_cur  (.mf(sts_q[4:0]),    .legal(cur_ok),  .bank(bank));

  logic unused_ok;
  assign unused_ok = ^{boot_bk, new_bk, cur_ok};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sts_q <= boot_ok ? boot_sts : DW'(SAFE_STS);
    end else if (we) begin
      if (new_ok) sts_q <= wdata;
      else        sts_q <= {wdata[DW-1:5], sts_q[4:0]};
    end
  end
endmodule

// File: rtl/brf_gpr_store.sv
module brf_gpr_store
  import brf_pkg::*;
#(
  parameter int DW    = 32,
  parameter int NREG  = 16,
  parameter int HI_LO = 8,
  parameter int HI_N  = 5,
  parameter int NRP   = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  bank_e                   bank,
  input  logic                    we,
  input  logic [$clog2(NREG)-1:0] widx,
  input  logic [DW-1:0]           wdata,
  input  logic                    ssr_we,
  input  logic [DW-1:0]           ssr_wdata,
  input  logic [$clog2(NREG)-1:0] ridx [NRP],
  output logic [DW-1:0]           rdata [NRP],
  output logic [DW-1:0]           ssr_q
);
  localparam int IW     = $clog2(NREG);
  localparam int SP_IDX = NREG - 3;
  localparam int LR_IDX = NREG - 2;
  localparam int HW     = $clog2(HI_N);

  logic [DW-1:0] com_q [NREG];
  logic [DW-1:0] fhi_q [HI_N];
  logic [DW-1:0] sp_q  [NBANK];
  logic [DW-1:0] lr_q  [NBANK];
  logic [DW-1:0] ssr_m [NBANK];

  function automatic logic in_hi(input logic [IW-1:0] i);
    return (int'(i) >= HI_LO) && (int'(i) < HI_LO + HI_N);
  endfunction

  function automatic logic [HW-1:0] hi_off(input logic [IW-1:0] i);
    return HW'(int'(i) - HI_LO);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++)  com_q[i] <= '0;
      for (int i = 0; i < HI_N; i++)  fhi_q[i] <= '0;
      for (int b = 0; b < NBANK; b++) begin
        sp_q[b]  <= '0;
        lr_q[b]  <= '0;
        ssr_m[b] <= '0;
      end
    end else begin
      if (we) begin
        if (int'(widx) == SP_IDX)               sp_q[bank] <= wdata;
        else if (int'(widx) == LR_IDX)          lr_q[bank] <= wdata;
        else if (in_hi(widx) && bank == BK_FIQ) fhi_q[hi_off(widx)] <= wdata;
        else                                    com_q[widx] <= wdata;
      end
      if (ssr_we) ssr_m[bank] <= ssr_wdata;
    end
  end

  for (genvar p = 0; p < NRP; p++) begin : g_rport
    always_comb begin
      if (int'(ridx[p]) == SP_IDX)                rdata[p] = sp_q[bank];
      else if (int'(ridx[p]) == LR_IDX)           rdata[p] = lr_q[bank];
      else if (in_hi(ridx[p]) && bank == BK_FIQ)  rdata[p] = fhi_q[hi_off(ridx[p])];
      else                                        rdata[p] = com_q[ridx[p]];
    end
  end

  assign ssr_q = ssr_m[bank];
endmodule

// File: rtl/bankreg_file.sv
module bankreg_file
  import brf_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] boot_sts,
  input  logic [3:0]  rd_a_idx,
  output logic [31:0] rd_a_data,
  input  logic [3:0]  rd_b_idx,
  output logic [31:0] rd_b_data,
  input  logic        wr_en,
  input  logic [3:0]  wr_idx,
  input  logic [31:0] wr_data,
  input  logic        ssr_wr_en,
  input  logic [31:0] ssr_wr_data,
  output logic [31:0] ssr_q,
  input  logic        sts_wr_en,
  input  logic [31:0] sts_wr_data,
  output logic [31:0] sts_q,
  output logic [4:0]  cur_mode
);
  localparam int DW   = 32;
  localparam int NREG = 16;
  localparam int IW   = $clog2(NREG);

  bank_e         bank;
  logic [IW-1:0] ridx  [2];
  logic [DW-1:0] rdata [2];

  brf_status_ctl #(.DW(DW)) u_sts (
    .clk(clk), .rst_n(rst_n), .boot_sts(boot_sts),
    .we(sts_wr_en), .wdata(sts_wr_data), .sts_q(sts_q), .bank(bank)
  );

  assign ridx[0] = rd_a_idx;
  assign ridx[1] = rd_b_idx;

  brf_gpr_store #(.DW(DW), .NREG(NREG), .HI_LO(8), .HI_N(5), .NRP(2)) u_gpr (
    .clk(clk), .rst_n(rst_n), .bank(bank),
    .we(wr_en), .widx(wr_idx), .wdata(wr_data),
    .ssr_we(ssr_wr_en), .ssr_wdata(ssr_wr_data),
    .ridx(ridx), .rdata(rdata), .ssr_q(ssr_q)
  );

  assign rd_a_data = rdata[0];
  assign rd_b_data = rdata[1];
  assign cur_mode  = sts_q[4:0];
endmodule

// File: rtl/brf_checker.sv
module brf_checker (
  input logic        clk,
  input logic        rst_n,
  input logic [3:0]  rd_a_idx,
  input logic [31:0] rd_a_data,
  input logic        wr_en,
  input logic        sts_wr_en,
  input logic [31:0] sts_wr_data,
  input logic [31:0] sts_q,
  input logic [4:0]  cur_mode
);
  function automatic logic ok_mode(input logic [4:0] m);
    return m == 5'h10 || m == 5'h11 || m == 5'h12 || m == 5'h13 ||
           m == 5'h17 || m == 5'h1B || m == 5'h1F;
  endfunction

  AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    ok_mode(cur_mode)); // R1

  AST_LEGAL_WRITE_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_wr_en && ok_mode(sts_wr_data[4:0])) |=> (sts_q == $past(sts_wr_data))); // R3

  AST_ILLEGAL_KEEPS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_wr_en && !ok_mode(sts_wr_data[4:0])) |=> (cur_mode == $past(cur_mode))); // R4

  AST_STS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !sts_wr_en |=> $stable(sts_q)); // R3

  AST_UNBANKED_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && (rd_a_idx < 4'd8 || rd_a_idx == 4'd15)) |=>
      ((rd_a_idx != $past(rd_a_idx)) || (rd_a_data == $past(rd_a_data)))); // R8
endmodule

bind bankreg_file brf_checker u_chk (
  .clk(clk), .rst_n(rst_n), .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
  .wr_en(wr_en), .sts_wr_en(sts_wr_en), .sts_wr_data(sts_wr_data),
  .sts_q(sts_q), .cur_mode(cur_mode)
);

// File: tb/sim_bankreg_file.sv
module sim_bankreg_file;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n;
  logic [31:0] boot_sts;
  logic [3:0]  rd_a_idx, rd_b_idx, wr_idx;
  logic [31:0] rd_a_data, rd_b_data, wr_data, ssr_wr_data, ssr_q, sts_wr_data, sts_q;
  logic        wr_en, ssr_wr_en, sts_wr_en;
  logic [4:0]  cur_mode;

  bankreg_file u0 (.*);

  int checks = 0, fails = 0;
  bit done = 0;

  // Reference model: one visible register set plus saved copies, swapped on a mode change.
  logic [31:0] vis [16];
  logic [31:0] vssr, msts;
  logic [31:0] bsp [6], blr [6], bssr [6], fhi [5], uhi [5];

  function automatic int bk(input logic [4:0] m);
    case (m)
      5'h10, 5'h1F: return 0;
      5'h11: return 1;
      5'h12: return 2;
      5'h13: return 3;
      5'h17: return 4;
      5'h1B: return 5;
      default: return -1;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h t=%0t", tag, got, exp, $time);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 16; i++) vis[i] = '0;
    for (int i = 0; i < 6; i++) begin bsp[i] = '0; blr[i] = '0; bssr[i] = '0; end
    for (int i = 0; i < 5; i++) begin fhi[i] = '0; uhi[i] = '0; end
    vssr = '0;
    msts = (bk(boot_sts[4:0]) >= 0) ? boot_sts : 32'h0000_00D3;
  endtask

  task automatic model_edge();
    int ob, nb;
    if (wr_en) vis[wr_idx] = wr_data;
    if (ssr_wr_en) vssr = ssr_wr_data;
    if (sts_wr_en) begin
      nb = bk(sts_wr_data[4:0]);
      ob = bk(msts[4:0]);
      if (nb < 0) msts = {sts_wr_data[31:5], msts[4:0]};
      else begin
        if (nb != ob) begin
          bsp[ob] = vis[13]; blr[ob] = vis[14]; bssr[ob] = vssr;
          if (ob == 1) for (int i = 0; i < 5; i++) begin fhi[i] = vis[8+i]; vis[8+i] = uhi[i]; end
          vis[13] = bsp[nb]; vis[14] = blr[nb]; vssr = bssr[nb];
          if (nb == 1) for (int i = 0; i < 5; i++) begin uhi[i] = vis[8+i]; vis[8+i] = fhi[i]; end
        end
        msts = sts_wr_data;
      end
    end
  endtask

  function automatic string rtag(input logic [3:0] i);
    if (i == 13 || i == 14) return "R5";
    if (i >= 8 && i <= 12) return "R6";
    return "R8";
  endfunction

  task automatic compare_all();
    chk({rtag(rd_a_idx), " portA"}, rd_a_data, vis[rd_a_idx]);
    chk({rtag(rd_b_idx), " R10 portB"}, rd_b_data, vis[rd_b_idx]);
    chk("R7 ssr", ssr_q, vssr);
    chk("R3/R4 status", sts_q, msts);
    chk("R1 mode", {27'd0, cur_mode}, {27'd0, msts[4:0]});
  endtask

  // Called just after a negedge with inputs set; compares, then advances one edge.
  task automatic tick();
    #1 compare_all();
    @(posedge clk);
    model_edge();
    @(negedge clk);
  endtask

  task automatic idle();
    wr_en = 0; ssr_wr_en = 0; sts_wr_en = 0;
  endtask

  task automatic do_reset(input logic [31:0] b);
    idle();
    boot_sts = b; rst_n = 0;
    repeat (3) @(negedge clk);
    model_reset();
    #1 chk("R2 reset status", sts_q, msts);
    chk("R2 reset reg", rd_a_data, 32'd0);
    chk("R2 reset ssr", ssr_q, 32'd0);
    rst_n = 1;
  endtask

  task automatic wr(input logic [3:0] i, input logic [31:0] d);
    idle(); wr_en = 1; wr_idx = i; wr_data = d; tick(); idle();
  endtask

  task automatic stw(input logic [31:0] v);
    idle(); sts_wr_en = 1; sts_wr_data = v; tick(); idle();
  endtask

  task automatic rd(input string tag, input logic [3:0] i, input logic [31:0] exp);
    idle(); rd_a_idx = i; rd_b_idx = i;
    #1 chk(tag, rd_a_data, exp);
    chk({tag, " R10"}, rd_b_data, exp);
    tick();
  endtask

  initial begin
    #(5ns * 150000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL R0 watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  localparam logic [4:0] MODES [9] = '{5'h10, 5'h11, 5'h12, 5'h13, 5'h17, 5'h1B, 5'h1F, 5'h00, 5'h15};

  initial begin
    rd_a_idx = 0; rd_b_idx = 0; wr_idx = 0; wr_data = 0;
    ssr_wr_data = 0; sts_wr_data = 0;
    @(negedge clk);
    // R2: illegal boot mode forces supervisor with both disable bits
    do_reset(32'hFFFF_FF05);
    chk("R2 forced svc", sts_q, 32'h0000_00D3);
    do_reset(32'h0000_0010);
    chk("R2 legal boot kept", sts_q, 32'h0000_0010);
    do_reset(32'h0000_0013);
    // R5: per-mode R13
    wr(13, 32'h1111_0013);
    stw(32'h0000_00D1);
    rd("R5 fiq sp fresh", 13, 32'h0);
    // R6: fiq private R8
    wr(8, 32'h0000_0088);
    wr(3, 32'h0000_0033);
    stw(32'h0000_0010);
    rd("R6 usr r8 hidden", 8, 32'h0);
    rd("R8 r3 shared", 3, 32'h0000_0033);
    // R3: same-mode write to system (user bank) keeps banked values
    wr(14, 32'h0000_1414);
    stw(32'h0000_001F);
    rd("R3 usr-sys same bank", 14, 32'h0000_1414);
    // R4: illegal mode write keeps mode
    stw(32'hF000_0005);
    chk("R4 mode kept", {27'd0, cur_mode}, 32'h1F);
    chk("R4 upper bits", sts_q, 32'hF000_001F);
    // R9: write collides with mode change, lands in outgoing bank
    idle(); wr_en = 1; wr_idx = 14; wr_data = 32'hCAFE_0014;
    ssr_wr_en = 1; ssr_wr_data = 32'h5A5A_0001;
    sts_wr_en = 1; sts_wr_data = 32'h0000_0012; tick(); idle();
    rd("R9 incoming lr", 14, 32'h0);
    stw(32'h0000_0013);
    rd("R5 svc sp back", 13, 32'h1111_0013);
    stw(32'h0000_0010);
    rd("R9 outgoing lr kept", 14, 32'hCAFE_0014);
    #1 chk("R9 R7 outgoing ssr", ssr_q, 32'h5A5A_0001);
    stw(32'h0000_0011);
    rd("R6 fiq r8 back", 8, 32'h0000_0088);
    // random mix, model compared every cycle
    for (int c = 0; c < 4000; c++) begin
      logic [31:0] r;
      r = $urandom;
      idle();
      rd_a_idx = 4'($urandom); rd_b_idx = 4'($urandom);
      wr_en = r[0]; wr_idx = 4'($urandom); wr_data = $urandom;
      ssr_wr_en = (r[2:1] == 0); ssr_wr_data = $urandom;
      sts_wr_en = (r[4:3] == 0);
      sts_wr_data = {r[31:5], MODES[$urandom % 9]};
      tick();
    end
    idle();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule